// File: doc/BRIEF.md
# Decimal Adjust Unit

The decimal adjust unit repairs a binary arithmetic result so that it reads as binary-coded decimal again. It works on a 16-bit accumulator value and the carry and half-carry (auxiliary) flags left by the arithmetic step. It covers six corrections. Four work on unpacked digits, one digit per byte: fix after add, fix after subtract, fold two digits into one binary byte with an arbitrary base before a divide, and split a binary byte into two digits with an arbitrary base after a multiply. Two work on packed digits, two per byte: fix after add and fix after subtract.

A request is a one-cycle `start` pulse carrying `op`, `acc_in`, `base`, `cf_in` and `af_in`. The unit accepts it only while `idle` is high. Otherwise the request is dropped, so the requester must hold it back until `idle` returns. Five operations finish in one cycle. The split runs on an 8-step restoring divider and keeps `idle` low for that time. Every accepted request ends with a one-cycle `done` pulse. The result and flag outputs are registers and hold their value until the next completion that writes them.

Top module: `dau_top`

## Requirements
- R1: While reset (`rst_n` low) is applied, `result` and all five flags are 0, `done` and `div_err` are 0, and `idle` is 1.
- R2: Op code 0 (unpacked fix after add): if `acc_in[3:0]` > 9 or `af_in`=1, the value becomes (acc_in + 0x106), and `cf` and `af` are both set to 1. Otherwise the value is `acc_in` and `cf` and `af` are both cleared.
- R3: Op code 1 (unpacked fix after subtract) uses the same test as R2 but subtracts 0x106. For op codes 0 and 1, `result` is the value ANDed with 0xFF0F, `sf`=0, `zf` is set when all 16 result bits are zero, and `pf`=1 when `result[7:0]` has an even number of ones.
- R4: Op code 4 (packed fix after add) works on `acc_in[7:0]`. If the low nibble > 9 or `af_in`=1, it adds 6 and sets `af`, else it clears `af`. Then, if the original byte > 0x99 or `cf_in`=1, it adds 0x60 and sets `cf`, else it clears `cf`. `result[15:8]` passes `acc_in[15:8]` through. `sf` is result bit 7, `zf` is set when the low byte is zero, and `pf` follows the parity rule of R3.
- R5: Op code 5 (packed fix after subtract): if the low nibble > 9 or `af_in`=1, it subtracts 6, sets `af`, and sets `cf` when `cf_in`=1 or the byte < 6; otherwise `af` and `cf` are cleared. Then, if the original byte > 0x99 or `cf_in`=1, it subtracts 0x60 and forces `cf`=1. The high byte, `sf`, `zf` and `pf` behave as in R4.
- R6: Op code 2 (fold before divide): `result` = {0x00, (acc_in[7:0] + base × acc_in[15:8]) mod 256}.
- R7: Op code 3 (split after multiply) with a non-zero base: `result[15:8]` = acc_in[7:0] / base and `result[7:0]` = acc_in[7:0] mod base. `done` rises at the ninth rising edge, counting the edge that samples `start` as the first. For every other op code, `done` rises at the edge that samples `start`.
- R8: For op codes 2 and 3, `cf` and `af` are cleared, `sf` is `result[7]`, `zf` is set when `result[7:0]` is zero, and `pf` follows the parity rule of R3.
- R9: Op code 3 with `base`=0 raises `div_err` and `done` together for one cycle, at the edge that samples `start`. It leaves `result` and all flags unchanged and keeps `idle` high.
- R10: While `idle` is low, `start` is ignored, including at the edge where the split completes. Such a request produces no `done` and changes neither `result` nor the flags.
- R11: Op codes 6 and 7 produce a `done` pulse and leave `result` and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted only while idle |
| op | input | 3 | Operation code |
| acc_in | input | 16 | Accumulator operand |
| base | input | 8 | Number base for the fold and split operations |
| cf_in | input | 1 | Incoming carry flag |
| af_in | input | 1 | Incoming auxiliary flag |
| idle | output | 1 | High when a request can be accepted |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | One-cycle pulse: split requested with a zero base |
| result | output | 16 | Adjusted value |
| cf | output | 1 | Carry flag out |
| af | output | 1 | Auxiliary flag out |
| zf | output | 1 | Zero flag out |
| sf | output | 1 | Sign flag out |
| pf | output | 1 | Parity flag out (1 = even ones in low byte) |

## Verification
Two events can land on the same clock edge: the final divider step of a split writing its result, and a new request arriving on `start`. The bench provokes this by raising `start` for a one-cycle operation exactly at the edge where the split finishes, and again at one edge in the middle of the split. It passes when the result equals the split's quotient and remainder, `done` shows a single pulse, and the following cycle has neither a second pulse nor any change of result or flags.

// File: rtl/dau_pkg.sv
package dau_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  typedef enum logic [2:0] {
    OP_UADD  = 3'd0,
    OP_USUB  = 3'd1,
    OP_COMB  = 3'd2,
    OP_SPLIT = 3'd3,
    OP_PADD  = 3'd4,
    OP_PSUB  = 3'd5
  } dau_op_e;
endpackage

// File: rtl/dau_unpacked_adj.sv
module dau_unpacked_adj #(
  parameter int W = dau_pkg::BYTE_W
) (
  input  logic [2*W-1:0] acc,
  input  logic           af_in,
  input  logic           sub,
  output logic [2*W-1:0] res,
  output logic           adj
);
  localparam int AW = 2*W;
  localparam logic [AW-1:0] STEP = AW'((1 << W) + 6);
  localparam logic [AW-1:0] KEEP = {{W{1'b1}}, {(W-dau_pkg::NIB_W){1'b0}}, {dau_pkg::NIB_W{1'b1}}};

  logic [AW-1:0] moved;

  always_comb begin
    adj   = (acc[dau_pkg::NIB_W-1:0] > 4'd9) || af_in;
    moved = sub ? (acc - STEP) : (acc + STEP);
    res   = (adj ? moved : acc) & KEEP;
  end
endmodule

// File: rtl/dau_packed_adj.sv
module dau_packed_adj #(
  parameter int W = dau_pkg::BYTE_W
) (
  input  logic [W-1:0] d,
  input  logic         cf_in,
  input  logic         af_in,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         cf_o,
  output logic         af_o
);
  localparam logic [W-1:0] LO_STEP = W'(6);
  localparam logic [W-1:0] HI_STEP = W'(8'h60);
  localparam logic [W-1:0] HI_LIM  = W'(8'h99);

  logic         lo_fix;
  logic         hi_fix;
  logic [W-1:0] lo_amt;
  logic [W-1:0] hi_amt;

  always_comb begin
    lo_fix = (d[dau_pkg::NIB_W-1:0] > 4'd9) || af_in;
    hi_fix = (d > HI_LIM) || cf_in;
    lo_amt = lo_fix ? LO_STEP : '0;
    hi_amt = hi_fix ? HI_STEP : '0;
    af_o   = lo_fix;
    if (sub) begin
      res  = d - lo_amt - hi_amt;
      cf_o = hi_fix || (lo_fix && (d < LO_STEP));
    end else begin
      res  = d + lo_amt + hi_amt;
      cf_o = hi_fix;
    end
  end
endmodule

// File: rtl/dau_base_comb.sv
module dau_base_comb #(
  parameter int W = dau_pkg::BYTE_W
) (
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] base,
  output logic [W-1:0] res
);
  logic [2*W-1:0] prod;

  always_comb begin
    prod = base * hi;
    res  = lo + prod[W-1:0];
  end
endmodule

// File: rtl/dau_divider.sv
module dau_divider #(
  parameter int W = dau_pkg::BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         last,
  output logic [W-1:0] quo_nx,
  output logic [W-1:0] rem_nx
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  rem;
  logic [W-1:0]  quo;
  logic [W-1:0]  dvs;
  logic [W:0]    trial;
  logic [W:0]    diff;
  logic          fits;

  always_comb begin
    trial  = {rem, quo[W-1]};
    diff   = trial - {1'b0, dvs};
    fits   = trial >= {1'b0, dvs};
    rem_nx = fits ? diff[W-1:0] : trial[W-1:0];
    quo_nx = {quo[W-2:0], fits};
    last   = busy && (cnt == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      rem  <= '0;
      quo  <= '0;
      dvs  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= '0;
      rem  <= '0;
      quo  <= dividend;
      dvs  <= divisor;
    end else if (busy) begin
      rem <= rem_nx;
      quo <= quo_nx;
      cnt <= cnt + CW'(1);
      if (last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/dau_top.sv
module dau_top #(
  parameter int W = dau_pkg::BYTE_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     op,
  input  logic [2*W-1:0] acc_in,
  input  logic [W-1:0]   base,
  input  logic           cf_in,
  input  logic           af_in,
  output logic           idle,
  output logic           done,
  output logic           div_err,
  output logic [2*W-1:0] result,
  output logic           cf,
  output logic           af,
  output logic           zf,
  output logic           sf,
  output logic           pf
);
  import dau_pkg::*;

  logic [2*W-1:0] u_res;
  logic           u_adj;
  logic [W-1:0]   p_res;
  logic           p_cf;
  logic           p_af;
  logic [W-1:0]   c_res;
  logic           dv_busy;
  logic           dv_last;
  logic           dv_load;
  logic [W-1:0]   dv_quo;
  logic [W-1:0]   dv_rem;

  logic [2*W-1:0] n_res;
  logic           n_cf, n_af, n_zf, n_sf, n_pf;
  logic           n_wr;
  logic           take;

  dau_unpacked_adj #(.W(W)) u_unp (
    .acc   (acc_in),
    .af_in (af_in),
    .sub   (op == OP_USUB),
    .res   (u_res),
    .adj   (u_adj)
  );

  dau_packed_adj #(.W(W)) u_pck (
    .d     (acc_in[W-1:0]),
    .cf_in (cf_in),
    .af_in (af_in),
    .sub   (op == OP_PSUB),
    .res   (p_res),
    .cf_o  (p_cf),
    .af_o  (p_af)
  );

  dau_base_comb #(.W(W)) u_cmb (
    .lo   (acc_in[W-1:0]),
    .hi   (acc_in[2*W-1:W]),
    .base (base),
    .res  (c_res)
  );

  assign take    = start && !dv_busy;
  assign dv_load = take && (op == OP_SPLIT) && (base != '0);
  assign idle    = !dv_busy;

  dau_divider #(.W(W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dv_load),
    .dividend (acc_in[W-1:0]),
    .divisor  (base),
    .busy     (dv_busy),
    .last     (dv_last),
    .quo_nx   (dv_quo),
    .rem_nx   (dv_rem)
  );

  always_comb begin
    n_res = result;
    n_cf  = cf;
    n_af  = af;
    n_zf  = zf;
    n_sf  = sf;
    n_pf  = pf;
    n_wr  = 1'b0;
    case (op)
      OP_UADD, OP_USUB: begin
        n_res = u_res;
        n_cf  = u_adj;
        n_af  = u_adj;
        n_sf  = 1'b0;
        n_zf  = (u_res == '0);
        n_pf  = ~^u_res[W-1:0];
        n_wr  = 1'b1;
      end
      OP_PADD, OP_PSUB: begin
        n_res = {acc_in[2*W-1:W], p_res};
        n_cf  = p_cf;
        n_af  = p_af;
        n_sf  = p_res[W-1];
        n_zf  = (p_res == '0);
        n_pf  = ~^p_res;
        n_wr  = 1'b1;
      end
      OP_COMB: begin
        n_res = {{W{1'b0}}, c_res};
        n_cf  = 1'b0;
        n_af  = 1'b0;
        n_sf  = c_res[W-1];
        n_zf  = (c_res == '0);
        n_pf  = ~^c_res;
        n_wr  = 1'b1;
      end
      default: n_wr = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result  <= '0;
      cf      <= 1'b0;
      af      <= 1'b0;
      zf      <= 1'b0;
      sf      <= 1'b0;
      pf      <= 1'b0;
      done    <= 1'b0;
      div_err <= 1'b0;
    end else begin
      done    <= 1'b0;
      div_err <= 1'b0;
      if (dv_last) begin
        result <= {dv_quo, dv_rem};
        cf     <= 1'b0;
        af     <= 1'b0;
        sf     <= dv_rem[W-1];
        zf     <= (dv_rem == '0);
        pf     <= ~^dv_rem;
        done   <= 1'b1;
      end else if (take) begin
        if (op == OP_SPLIT) begin
          if (base == '0) begin
            done    <= 1'b1;
            div_err <= 1'b1;
          end
        end else begin
          done <= 1'b1;
          if (n_wr) begin
            result <= n_res;
            cf     <= n_cf;
            af     <= n_af;
            zf     <= n_zf;
            sf     <= n_sf;
            pf     <= n_pf;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dau_checker.sv
module dau_checker #(
  parameter int W = dau_pkg::BYTE_W
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [2:0]     op,
  input logic           idle,
  input logic           done,
  input logic           div_err,
  input logic [2*W-1:0] result,
  input logic           cf,
  input logic           af,
  input logic           sf
);
  import dau_pkg::*;

  logic [2:0] last_op;

  always_ff @(posedge clk) begin
    if (!rst_n) last_op <= 3'd7;
    else if (start && idle) last_op <= op;
  end

  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |-> done);

  a_r9_err_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |-> $stable(result));

  a_r10_launch_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle) |-> !done);

  a_r7_finish_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> done);

  a_r3_unpacked_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (last_op == OP_UADD || last_op == OP_USUB)) |-> (!sf && result[W-1:4] == '0));

  a_r6_fold_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && last_op == OP_COMB) |-> (result[2*W-1:W] == '0 && !cf && !af));

  a_r8_split_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_err && last_op == OP_SPLIT) |-> (!cf && !af));
endmodule

bind dau_top dau_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .op      (op),
  .idle    (idle),
  .done    (done),
  .div_err (div_err),
  .result  (result),
  .cf      (cf),
  .af      (af),
  .sf      (sf)
);

// File: tb/sim_dau_top.sv
`timescale 1ns/1ps
module sim_dau_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  op;
  logic [15:0] acc_in;
  logic [7:0]  base;
  logic        cf_in, af_in;
  logic        idle, done, div_err;
  logic [15:0] result;
  logic        cf, af, zf, sf, pf;

  int vecs = 0;
  int errs = 0;
  int cyc  = 0;
  logic [21:0] expv;

  always #2 clk = ~clk;

  dau_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .acc_in(acc_in),
    .base(base), .cf_in(cf_in), .af_in(af_in), .idle(idle), .done(done),
    .div_err(div_err), .result(result), .cf(cf), .af(af), .zf(zf),
    .sf(sf), .pf(pf)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  function automatic logic [22:0] observed();
    return {done, result, cf, af, zf, sf, pf, div_err};
  endfunction

  task automatic cmp(input string req, input logic [22:0] act, input logic [22:0] exp_v);
    vecs++;
    if (act !== exp_v) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  // Arithmetic model; prev holds {result, cf, af, zf, sf, pf, err}
  function automatic logic [21:0] model(input logic [2:0] o, input logic [15:0] a,
                                        input logic [7:0] b, input logic c, input logic f,
                                        input logic [21:0] prev);
    logic [15:0] r;
    logic [7:0]  lo, q;
    logic        nc, na, nz, ns, np, e, byte_flags;
    int          t;
    r = prev[21:6]; nc = prev[5]; na = prev[4]; nz = prev[3]; ns = prev[2]; np = prev[1];
    e = 1'b0; byte_flags = 1'b0; lo = 8'h00;
    case (o)
      3'd0, 3'd1: begin
        if (a[3:0] > 4'd9 || f) begin
          r = (o == 3'd0) ? a + 16'd262 : a - 16'd262;
          nc = 1'b1; na = 1'b1;
        end else begin
          r = a; nc = 1'b0; na = 1'b0;
        end
        r = r & 16'hFF0F;
        ns = 1'b0; nz = (r == 16'h0); np = ~^r[7:0];
      end
      3'd4: begin
        t = int'(a[7:0]); na = 1'b0; nc = 1'b0;
        if (a[3:0] > 4'd9 || f) begin t = t + 6; na = 1'b1; end
        if (a[7:0] > 8'h99 || c) begin t = t + 96; nc = 1'b1; end
        lo = t[7:0]; r = {a[15:8], lo}; byte_flags = 1'b1;
      end
      3'd5: begin
        t = int'(a[7:0]); na = 1'b0; nc = 1'b0;
        if (a[3:0] > 4'd9 || f) begin t = t - 6; na = 1'b1; nc = c || (a[7:0] < 8'd6); end
        if (a[7:0] > 8'h99 || c) begin t = t - 96; nc = 1'b1; end
        lo = t[7:0]; r = {a[15:8], lo}; byte_flags = 1'b1;
      end
      3'd2: begin
        t = int'(a[7:0]) + int'(b) * int'(a[15:8]);
        lo = t[7:0]; r = {8'h00, lo}; nc = 1'b0; na = 1'b0; byte_flags = 1'b1;
      end
      3'd3: begin
        if (b == 8'h00) e = 1'b1;
        else begin
          q = a[7:0] / b; lo = a[7:0] % b;
          r = {q, lo}; nc = 1'b0; na = 1'b0; byte_flags = 1'b1;
        end
      end
      default: e = 1'b0;
    endcase
    if (byte_flags) begin ns = lo[7]; nz = (lo == 8'h00); np = ~^lo; end
    return {r, nc, na, nz, ns, np, e};
  endfunction

  task automatic issue(input logic [2:0] o, input logic [15:0] a, input logic [7:0] b,
                       input logic c, input logic f);
    @(negedge clk);
    op = o; acc_in = a; base = b; cf_in = c; af_in = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_op(input string req, input logic [2:0] o, input logic [15:0] a,
                       input logic [7:0] b, input logic c, input logic f);
    int lat;
    logic [21:0] nx;
    issue(o, a, b, c, f);
    lat = 1;
    if (o == 3'd3 && b != 8'h00) begin
      while (!done && lat < 40) begin @(negedge clk); lat++; end
      if (a[7:0] == 8'h00) cmp("R7 latency", 23'(lat), 23'd9);
    end
    nx = model(o, a, b, c, f, expv);
    cmp(req, observed(), {1'b1, nx});
    if (o == 3'd3 && b == 8'h00) cmp("R9 idle kept high", {22'h0, idle}, 23'd1);
    expv = {nx[21:1], 1'b0};
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 3'd0; acc_in = 16'h0; base = 8'h0;
    cf_in = 1'b0; af_in = 1'b0; expv = '0;
    repeat (3) @(negedge clk);
    cmp("R1 reset state", {observed()[22:0]}, 23'h0);
    cmp("R1 idle in reset", {22'h0, idle}, 23'd1);
    rst_n = 1'b1;

    // R2 / R3: unpacked fixes over every low byte, three high bytes, both af values
    for (int h = 0; h < 3; h++)
      for (int v = 0; v < 256; v++)
        for (int f = 0; f < 2; f++) begin
          logic [7:0] hb;
          hb = (h == 0) ? 8'h00 : (h == 1) ? 8'h37 : 8'hFF;
          do_op("R2 unpacked add", 3'd0, {hb, 8'(v)}, 8'h00, v[0], f[0]);
          do_op("R3 unpacked sub", 3'd1, {hb, 8'(v)}, 8'h00, v[1], f[0]);
        end

    // R4 / R5: packed fixes, exhaustive over byte, carry and auxiliary
    for (int v = 0; v < 256; v++)
      for (int c = 0; c < 2; c++)
        for (int f = 0; f < 2; f++) begin
          do_op("R4 packed add", 3'd4, {8'(v) ^ 8'h5A, 8'(v)}, 8'h00, c[0], f[0]);
          do_op("R5 packed sub", 3'd5, {8'(v) ^ 8'hA5, 8'(v)}, 8'h00, c[0], f[0]);
        end

    // R6 / R8: fold with several bases
    for (int hv = 0; hv < 256; hv++)
      for (int l = 0; l < 3; l++)
        for (int bi = 0; bi < 4; bi++) begin
          logic [7:0] lv, bv;
          lv = (l == 0) ? 8'h00 : (l == 1) ? 8'h09 : 8'hF3;
          bv = (bi == 0) ? 8'd10 : (bi == 1) ? 8'd0 : (bi == 2) ? 8'd255 : 8'd7;
          do_op("R6 R8 fold", 3'd2, {8'(hv), lv}, bv, hv[0], hv[1]);
        end

    // R7 / R8: split with several bases
    for (int v = 0; v < 256; v++)
      for (int bi = 0; bi < 5; bi++) begin
        logic [7:0] bv;
        bv = (bi == 0) ? 8'd10 : (bi == 1) ? 8'd1 : (bi == 2) ? 8'd7 : (bi == 3) ? 8'd255 : 8'd16;
        do_op("R7 R8 split", 3'd3, {8'hC3, 8'(v)}, bv, v[0], v[1]);
      end

    // R9: zero base
    do_op("R9 zero base", 3'd3, 16'h0042, 8'h00, 1'b1, 1'b1);
    do_op("R9 zero base", 3'd3, 16'h00FF, 8'h00, 1'b0, 1'b0);

    // R11: reserved codes
    do_op("R11 code 6 no change", 3'd6, 16'h1234, 8'h05, 1'b1, 1'b1);
    do_op("R11 code 7 no change", 3'd7, 16'hFFFF, 8'h00, 1'b0, 1'b1);

    // R10: requests during a split, including at the finishing edge
    begin
      logic [21:0] nx;
      issue(3'd3, 16'h0064, 8'd10, 1'b0, 1'b0);
      for (int j = 1; j <= 8; j++) begin
        if (j == 2) cmp("R10 idle low while busy", {22'h0, idle}, 23'd0);
        op = 3'd0; acc_in = 16'h000F; base = 8'd0; af_in = 1'b1;
        start = (j == 3) || (j == 8);
        @(negedge clk);
      end
      start = 1'b0;
      nx = model(3'd3, 16'h0064, 8'd10, 1'b0, 1'b0, expv);
      cmp("R10 split result despite requests", observed(), {1'b1, nx});
      @(negedge clk);
      cmp("R10 finishing-edge request ignored", observed(), {1'b0, nx});
      expv = nx;
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule